// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block is a clocked model of the control side of a byte-wide parallel EEPROM. The three active-low strobes (chip enable, output enable, write enable), the address, the data input and a low-supply inhibit are sampled on the system clock. The block works out which of read, write, standby or output-disable is requested. Reads return the addressed byte from an internal array, with an output-enable flag for the bidirectional data bus.

Write cycles are collected into a page buffer. The address is taken when the write condition begins, which is at the later falling strobe. The data is taken when the condition ends, which is at the earlier rising strobe. Either chip enable or write enable may be the controlling strobe.

A page closes when chip enable and write enable both stay unchanged for `T_LOAD` clock cycles. The block then runs a self-timed programming cycle of `T_PROG` cycles. During that cycle it writes only the loaded bytes into the array and holds the ready/busy output low. While it is busy, further writes are ignored. Reads during that time return the last loaded byte with its top bit inverted, so that software can poll for completion. `ADDR_W` is 13 for the full 8K-byte device; the elaboration default is smaller to keep the array modest.

Top module: `eepw_ctrl`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1 held, dq_oe is 1 and dq_out equals the array byte at addr by the fourth rising clock edge after the pins are applied, provided the block is ready.
- R2: dq_oe is 0 whenever ce_n=1, or oe_n=1, or we_n=0; in those cases dq_out is 0.
- R3: A write begins only while ce_n=0, we_n=0 and oe_n=1. The address is taken in the cycle this condition becomes true, and later changes of addr during the same write have no effect. With oe_n=0, no write takes place.
- R4: The data byte is the value of dq_in in the cycle the write condition ends, whichever of ce_n or we_n rises first.
- R5: The low PAGE_W address bits select a byte within a page, and the upper bits form the page tag. A byte whose tag differs from the open page's tag is dropped.
- R6: Programming starts only after T_LOAD consecutive cycles with no change on ce_n or we_n while a page is open. Only bytes loaded into the page are written; the other bytes of that page keep their contents.
- R7: rb_n is 0 for exactly T_PROG consecutive cycles per programming cycle and is 1 otherwise.
- R8: A write attempted while rb_n=0 changes nothing in the array and opens no page.
- R9: A read during programming returns the last loaded byte with bit DATA_W-1 inverted and the other bits unchanged.
- R10: A write attempted while lv_inhibit=1 is blocked. It does not load a byte and starts no programming cycle.
- R11: After reset, rb_n=1 and dq_oe=0, and no page is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Write data from the bus |
| lv_inhibit | input | 1 | Low-supply write inhibit, active high |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Drive enable for the data bus |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions assume that every strobe level lasts at least one clock cycle. They also assume that T_PROG is at least the page size, so that the sequencer can visit every slot of the page. Given that, they check the busy length, the tag match on every accepted byte, and that no byte is accepted during programming. The bench changes the pins only at falling clock edges and holds each strobe phase for one or more cycles. Inside a page, each byte follows the previous one well inside the load window. The checks that expect a page to close or stay closed wait well beyond T_LOAD.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strb_t;

  localparam strb_t STRB_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

  function automatic logic is_write(strb_t s);
    return !s.ce_n && !s.we_n && s.oe_n;
  endfunction

  function automatic logic is_read(strb_t s);
    return !s.ce_n && !s.oe_n && s.we_n;
  endfunction
endpackage

// File: rtl/eepw_pin_sampler.sv
module eepw_pin_sampler
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              inhibit,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_data,
  output logic              s_inh,
  output logic              rd_act,
  output logic              wr_rise,
  output logic              wr_fall,
  output logic              strb_edge
);
  strb_t strb_q;
  logic  ce_p, we_p, wr_p;
  logic  wr_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= STRB_IDLE;
      ce_p   <= 1'b1;
      we_p   <= 1'b1;
      wr_p   <= 1'b0;
      s_addr <= '0;
      s_data <= '0;
      s_inh  <= 1'b0;
    end else begin
      strb_q <= '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};
      ce_p   <= strb_q.ce_n;
      we_p   <= strb_q.we_n;
      wr_p   <= wr_now;
      s_addr <= addr;
      s_data <= dq_in;
      s_inh  <= inhibit;
    end
  end

  assign wr_now    = is_write(strb_q);
  assign rd_act    = is_read(strb_q);
  assign wr_rise   = wr_now && !wr_p;
  assign wr_fall   = !wr_now && wr_p;
  assign strb_edge = (strb_q.ce_n != ce_p) || (strb_q.we_n != we_p);
endmodule

// File: rtl/eepw_page_buf.sv
module eepw_page_buf #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter int T_LOAD = 100,
  parameter int T_PROG = 200
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        s_addr,
  input  logic [DATA_W-1:0]        s_data,
  input  logic                     s_inh,
  input  logic                     wr_rise,
  input  logic                     wr_fall,
  input  logic                     strb_edge,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     busy,
  output logic [DATA_W-1:0]        poll_byte,
  output logic                     byte_load,
  output logic                     prog_start,
  output logic                     page_open,
  output logic [(1<<PAGE_W)-1:0]   valid_mask,
  output logic [ADDR_W-PAGE_W-1:0] page_tag,
  output logic [ADDR_W-PAGE_W-1:0] load_tag
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(T_LOAD + 1);
  localparam int CNT_W = $clog2(T_PROG + 1);

  logic                armed;
  logic [ADDR_W-1:0]   cap_addr;
  logic [PAGE_W-1:0]   slot;
  logic                tag_ok;
  logic [TMR_W-1:0]    tmr;
  logic [CNT_W-1:0]    pcnt;
  logic                prog_done;
  logic [PAGE_W-1:0]   pslot;
  logic [DATA_W-1:0]   pbuf_q [PAGE];

  // write arming: decided when the write condition begins
  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      cap_addr <= '0;
    end else if (wr_rise) begin
      armed    <= !busy && !s_inh;
      cap_addr <= s_addr;
    end else if (wr_fall) begin
      armed    <= 1'b0;
    end
  end

  assign load_tag  = cap_addr[ADDR_W-1:PAGE_W];
  assign slot      = cap_addr[PAGE_W-1:0];
  assign tag_ok    = !page_open || (load_tag == page_tag);
  assign byte_load = wr_fall && armed && !busy && tag_ok;

  // page buffer storage
  always_ff @(posedge clk) begin
    if (byte_load) pbuf_q[slot] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_mask <= '0;
      page_open  <= 1'b0;
      page_tag   <= '0;
      poll_byte  <= '0;
    end else begin
      if (byte_load) begin
        valid_mask[slot] <= 1'b1;
        poll_byte        <= s_data;
        if (!page_open) page_tag <= load_tag;
      end else if (prog_done) begin
        valid_mask <= '0;
      end
      if (byte_load)       page_open <= 1'b1;
      else if (prog_start) page_open <= 1'b0;
    end
  end

  // byte-load window timer
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
    end else if (byte_load || strb_edge || !page_open) begin
      tmr <= '0;
    end else if (tmr != TMR_W'(T_LOAD)) begin
      tmr <= tmr + 1'b1;
    end
  end

  assign prog_start = page_open && !busy && !strb_edge && (tmr == TMR_W'(T_LOAD));

  // self-timed programming sequencer
  assign prog_done = busy && (pcnt == CNT_W'(T_PROG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      pcnt <= '0;
    end else if (prog_start) begin
      busy <= 1'b1;
      pcnt <= '0;
    end else if (busy) begin
      if (prog_done) busy <= 1'b0;
      pcnt <= pcnt + 1'b1;
    end
  end

  assign pslot     = pcnt[PAGE_W-1:0];
  assign mem_we    = busy && (pcnt < CNT_W'(PAGE)) && valid_mask[pslot];
  assign mem_waddr = {page_tag, pslot};
  assign mem_wdata = pbuf_q[pslot];
endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter int T_LOAD = 100,
  parameter int T_PROG = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              lv_inhibit,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rb_n
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TAG_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              s_inh, rd_act, wr_rise, wr_fall, strb_edge;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, rd_q, poll_byte;
  logic              busy, byte_load, prog_start, page_open;
  logic [PAGE-1:0]   valid_mask;
  logic [TAG_W-1:0]  page_tag, load_tag;
  logic              rd_d;

  eepw_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .inhibit(lv_inhibit),
    .s_addr(s_addr), .s_data(s_data), .s_inh(s_inh), .rd_act(rd_act),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .strb_edge(strb_edge)
  );

  eepw_page_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
    .T_LOAD(T_LOAD), .T_PROG(T_PROG)
  ) u_pg (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_data(s_data), .s_inh(s_inh),
    .wr_rise(wr_rise), .wr_fall(wr_fall), .strb_edge(strb_edge),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(busy), .poll_byte(poll_byte), .byte_load(byte_load),
    .prog_start(prog_start), .page_open(page_open), .valid_mask(valid_mask),
    .page_tag(page_tag), .load_tag(load_tag)
  );

  eepw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(s_addr), .rdata(rd_q)
  );

  // output stage, aligned with the registered array read
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d   <= 1'b0;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      rd_d  <= rd_act;
      dq_oe <= rd_d;
      if (!rd_d)    dq_out <= '0;
      else if (busy) dq_out <= {~poll_byte[DATA_W-1], poll_byte[DATA_W-2:0]};
      else          dq_out <= rd_q;
    end
  end

  assign rb_n = !busy;
endmodule

// File: rtl/eepw_ctrl_chk.sv
module eepw_ctrl_chk #(
  parameter int T_PROG = 200,
  parameter int PAGE   = 64,
  parameter int TAG_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             byte_load,
  input logic             prog_start,
  input logic             page_open,
  input logic [PAGE-1:0]  valid_mask,
  input logic [TAG_W-1:0] page_tag,
  input logic [TAG_W-1:0] load_tag,
  input logic             rb_n,
  input logic             dq_oe
);
  localparam int BC_W = $clog2(T_PROG + 2);
  logic [BC_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> (bcnt == BC_W'(T_PROG)));

  // R7
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < BC_W'(T_PROG)));

  // R8
  no_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    byte_load |-> !busy);

  // R5
  tag_match_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_load && page_open) |-> (load_tag == page_tag));

  // R6
  start_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> (valid_mask != '0));

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rb_n && !dq_oe && !page_open));
endmodule

bind eepw_ctrl eepw_ctrl_chk #(.T_PROG(T_PROG), .PAGE(PAGE), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .byte_load(byte_load),
  .prog_start(prog_start), .page_open(page_open), .valid_mask(valid_mask),
  .page_tag(page_tag), .load_tag(load_tag), .rb_n(rb_n), .dq_oe(dq_oe)
);

// File: tb/eepw_ctrl_tb.sv
module eepw_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PW = 2;
  localparam int TL = 8;
  localparam int TP = 12;
  localparam int NB = 1 << AW;
  localparam int PG = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic lv_inhibit = 1'b0;
  logic [DW-1:0] dq_out;
  logic dq_oe, rb_n;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] ref_mem [NB];

  eepw_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .T_LOAD(TL), .T_PROG(TP)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .lv_inhibit(lv_inhibit),
    .dq_out(dq_out), .dq_oe(dq_oe), .rb_n(rb_n)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  // write enable is the controlling strobe
  task automatic wr_w(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; tick();
    we_n = 1'b0; tick(); tick();
    we_n = 1'b1; tick();
    ce_n = 1'b1; tick();
  endtask

  // chip enable is the controlling strobe
  task automatic wr_e(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; dq_in = d; oe_n = 1'b1; we_n = 1'b0; tick();
    ce_n = 1'b0; tick(); tick();
    ce_n = 1'b1; tick();
    we_n = 1'b1; tick();
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (4) @(posedge clk);
    tick();
    d = dq_out; oe = dq_oe;
    idle(); tick();
  endtask

  task automatic wait_prog(output int len);
    int g = 0;
    while (rb_n === 1'b1 && g < 400) begin tick(); g++; end
    len = 0;
    while (rb_n === 1'b0 && len < 1000) begin len++; tick(); end
  endtask

  task automatic quiet_check(input string req, input int cycles);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      if (rb_n !== 1'b1) lows++;
      tick();
    end
    chk(lows == 0, req, lows, 0);
  endtask

  initial begin
    logic [DW-1:0] d;
    logic oe;
    int len;

    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11 reset state
    chk(rb_n === 1'b1, "R11 rb_n", int'(rb_n), 1);
    chk(dq_oe === 1'b0, "R11 dq_oe", int'(dq_oe), 0);

    // full sweep: every page, both controlling strobes, both byte orders
    for (int p = 0; p < NB / PG; p++) begin
      for (int b = 0; b < PG; b++) begin
        int bb = (p % 2 == 1) ? (PG - 1 - b) : b;
        int a = p * PG + bb;
        if (p % 2 == 0) wr_w(AW'(a), pat(a));
        else            wr_e(AW'(a), pat(a));
        ref_mem[a] = pat(a);
      end
      if (p == 0) begin
        // R6 window not yet expired
        chk(rb_n === 1'b1, "R6 early start", int'(rb_n), 1);
        tick(); tick();
        chk(rb_n === 1'b1, "R6 early start", int'(rb_n), 1);
      end
      wait_prog(len);
      chk(len == TP, "R7 busy length", len, TP);
    end

    for (int a = 0; a < NB; a++) begin
      rd(AW'(a), d, oe);
      chk(oe === 1'b1, "R1 dq_oe", int'(oe), 1);
      chk(d === ref_mem[a], "R1 data", int'(d), int'(ref_mem[a]));
    end

    // R2 non-read modes
    addr = 8'd5;
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; repeat (5) tick();
    chk(dq_oe === 1'b0 && dq_out === '0, "R2 standby", int'(dq_oe), 0);
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; repeat (5) tick();
    chk(dq_oe === 1'b0 && dq_out === '0, "R2 output disable", int'(dq_oe), 0);
    dq_in = 8'hC3;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; repeat (5) tick();
    chk(dq_oe === 1'b0 && dq_out === '0, "R2 write disable", int'(dq_oe), 0);
    idle(); tick();
    // R3 oe_n low blocks the write
    quiet_check("R3 no program with oe_n low", TL + TP + 6);
    rd(8'd5, d, oe);
    chk(d === ref_mem[5], "R3 oe_n low write", int'(d), int'(ref_mem[5]));

    // R3/R4 address at start, data at end of write condition
    addr = 8'd40; dq_in = 8'h11; oe_n = 1'b1; ce_n = 1'b0; tick();
    we_n = 1'b0; tick(); tick();
    addr = 8'd90; dq_in = 8'hA6; tick(); tick();
    we_n = 1'b1; tick();
    ce_n = 1'b1; tick();
    ref_mem[40] = 8'hA6;
    wait_prog(len);
    chk(len == TP, "R7 busy length", len, TP);
    rd(8'd40, d, oe);
    chk(d === 8'hA6, "R3 R4 captured byte", int'(d), 8'hA6);
    rd(8'd90, d, oe);
    chk(d === ref_mem[90], "R3 late address ignored", int'(d), int'(ref_mem[90]));

    // R5/R6 partial page plus a byte of another page
    wr_w(8'd41, 8'h5A); ref_mem[41] = 8'h5A;
    wr_e(8'd43, 8'h3C); ref_mem[43] = 8'h3C;
    wr_w(8'd81, 8'hF0);
    wait_prog(len);
    chk(len == TP, "R7 busy length", len, TP);
    quiet_check("R5 dropped byte opens no page", TL + TP + 6);
    for (int a = 40; a < 44; a++) begin
      rd(AW'(a), d, oe);
      chk(d === ref_mem[a], "R6 valid mask", int'(d), int'(ref_mem[a]));
    end
    rd(8'd81, d, oe);
    chk(d === ref_mem[81], "R5 foreign tag dropped", int'(d), int'(ref_mem[81]));

    // R8/R9 write and read while busy
    wr_w(8'd200, 8'h9D); ref_mem[200] = 8'h9D;
    begin
      int g = 0;
      while (rb_n === 1'b1 && g < 100) begin tick(); g++; end
    end
    rd(8'd200, d, oe);
    chk(oe === 1'b1 && rb_n === 1'b0, "R9 poll read in busy", int'(oe), 1);
    chk(d === 8'h1D, "R9 poll byte", int'(d), 8'h1D);
    wr_w(8'd120, 8'h00);
    begin
      int g = 0;
      while (rb_n === 1'b0 && g < 100) begin tick(); g++; end
    end
    quiet_check("R8 busy write opens no page", TL + TP + 6);
    rd(8'd120, d, oe);
    chk(d === ref_mem[120], "R8 busy write ignored", int'(d), int'(ref_mem[120]));
    rd(8'd200, d, oe);
    chk(d === 8'h9D, "R9 byte after busy", int'(d), 8'h9D);

    // R10 inhibit
    lv_inhibit = 1'b1;
    wr_e(8'd17, 8'h77);
    lv_inhibit = 1'b0;
    quiet_check("R10 inhibited write starts nothing", TL + TP + 6);
    rd(8'd17, d, oe);
    chk(d === ref_mem[17], "R10 inhibited data", int'(d), int'(ref_mem[17]));

    finish_run();
  end
endmodule